// File: doc/BRIEF.md
# Return-from-Interrupt State Restore Unit

This block works out the machine state word and the next fetch address that a return-from-interrupt operation produces in a 64-bit pipeline stage. When `op_valid` is high it reads the current state word, the saved address and the saved state word. One clock later it presents the new state word and the new fetch address, each with its own ok flag.

The restored state is not a plain copy of the saved word. Field positions use big-endian numbering: architectural bit n sits at vector index 63-n. Each field follows its own rule:
- The hypervisor bit and the machine-check enable depend on the current hypervisor state.
- The external-interrupt enable and the two relocation bits are forced on when the return goes to problem state.
- The three-bit transaction-state field is replaced only under a condition.
- A few architectural bits keep their current value.

Top module: `rfi_restore`

## Requirements
- R1: The new state takes the saved value at architectural bits 0-2, 4-28, 32, 37-41, 49-50, 52-57 and 60-63. Architectural bit n is vector index 63-n.
- R2: New architectural bit 3 (hypervisor) is the AND of the current and the saved bit 3.
- R3: New architectural bit 51 (machine-check enable) takes the saved bit 51 when the current bit 3 is 1. Otherwise it keeps the current bit 51.
- R4: New architectural bits 48, 58 and 59 are each the OR of their saved value and saved architectural bit 49 (problem state).
- R5: The transaction-state field is architectural bits 29-31, read with bit 29 as MSB. The new field keeps the current value when the current field is 3'b010 and the saved field is 3'b000. Otherwise it takes the saved field.
- R6: New architectural bits 33-36 and 42-47 keep their current values.
- R7: The new fetch address equals the saved address with its two least-significant vector bits cleared.
- R8: `state_ok` and `addr_ok` are high in the cycle after a cycle with `op_valid` high, and low after a cycle with `op_valid` low.
- R9: While no operation is presented, `new_state` and `new_addr` hold their last values.
- R10: A synchronous active-high `rst` clears `new_state` and `new_addr` to zero and drops both ok flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | A return-from-interrupt operation is presented this cycle |
| cur_state | input | 64 | Current machine state word |
| saved_addr | input | 64 | Saved return address |
| saved_state | input | 64 | Saved machine state word |
| new_state | output | 64 | Restored machine state word (registered) |
| state_ok | output | 1 | `new_state` is valid this cycle |
| new_addr | output | 64 | New fetch address (registered) |
| addr_ok | output | 1 | `new_addr` is valid this cycle |

## Verification
The bench targets the transaction-state exception, where the current field is 3'b010 and the saved field is 3'b000. A design that copied the field blindly would write 000 there instead of keeping 010. A design that tested only one of the two fields would keep the current value in cases where the saved value must win.

Further vectors cover:
- A return to problem state with the enable bits clear. A missing OR leaves interrupts and relocation off.
- A current hypervisor bit of 0. A design with the gate missing or inverted overwrites machine-check enable or raises the hypervisor bit.
- Opposite all-ones and all-zeros words. These catch a bit-order reversal and any preserved bit that is copied by mistake.

Idle cycles and a reset arriving mid-stream show whether the ok flags stick or the data fails to hold.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
  localparam int REG_W = 64;

  // architectural (big-endian) bit numbers
  localparam int ABIT_HV  = 3;
  localparam int ABIT_ME  = 51;
  localparam int ABIT_EE  = 48;
  localparam int ABIT_PR  = 49;
  localparam int ABIT_IR  = 58;
  localparam int ABIT_DR  = 59;
  localparam int ABIT_TS0 = 29;
  localparam int ABIT_TS2 = 31;

  localparam logic [2:0] TS_SUSPENDED = 3'b010;
  localparam logic [2:0] TS_NONE      = 3'b000;

  typedef enum logic [2:0] {
    RULE_COPY,
    RULE_KEEP,
    RULE_HV_AND,
    RULE_ME_GATE,
    RULE_OR_PR,
    RULE_TS
  } rule_e;

  function automatic int arch_idx(input int n);
    return REG_W - 1 - n;
  endfunction

  // rule that governs vector index i
  function automatic rule_e rule_for_idx(input int i);
    int n;
    n = REG_W - 1 - i;
    if (n == ABIT_HV) return RULE_HV_AND;
    if (n == ABIT_ME) return RULE_ME_GATE;
    if (n == ABIT_EE || n == ABIT_IR || n == ABIT_DR) return RULE_OR_PR;
    if (n >= ABIT_TS0 && n <= ABIT_TS2) return RULE_TS;
    if ((n >= 33 && n <= 36) || (n >= 42 && n <= 47)) return RULE_KEEP;
    return RULE_COPY;
  endfunction

  function automatic logic [REG_W-1:0] align_addr(input logic [REG_W-1:0] a,
                                                  input int low_bits);
    logic [REG_W-1:0] m;
    m = '1;
    for (int k = 0; k < REG_W; k++)
      if (k < low_bits) m[k] = 1'b0;
    return a & m;
  endfunction
endpackage

// File: rtl/rfi_state_merge.sv
module rfi_state_merge
  import rfi_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] saved,
  output logic [W-1:0] merged,
  output logic         ts_keep,
  output logic         hv_now,
  output logic         pr_return
);
  localparam int TS_HI = arch_idx(ABIT_TS0);
  localparam int TS_LO = arch_idx(ABIT_TS2);
  localparam int HV_I  = arch_idx(ABIT_HV);
  localparam int PR_I  = arch_idx(ABIT_PR);

  assign hv_now    = cur[HV_I];
  assign pr_return = saved[PR_I];
  assign ts_keep   = (cur[TS_HI:TS_LO] == TS_SUSPENDED) &&
                     (saved[TS_HI:TS_LO] == TS_NONE);

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam rule_e RULE = rule_for_idx(i);
    if (RULE == RULE_HV_AND) begin : g_hv
      assign merged[i] = cur[i] & saved[i];
    end else if (RULE == RULE_ME_GATE) begin : g_me
      assign merged[i] = hv_now ? saved[i] : cur[i];
    end else if (RULE == RULE_OR_PR) begin : g_or
      assign merged[i] = saved[i] | pr_return;
    end else if (RULE == RULE_TS) begin : g_ts
      assign merged[i] = ts_keep ? cur[i] : saved[i];
    end else if (RULE == RULE_KEEP) begin : g_keep
      assign merged[i] = cur[i];
    end else begin : g_copy
      assign merged[i] = saved[i];
    end
  end
endmodule

// File: rtl/rfi_addr_align.sv
module rfi_addr_align
  import rfi_pkg::*;
#(
  parameter int W        = REG_W,
  parameter int LOW_BITS = 2
) (
  input  logic [W-1:0] saved_addr,
  output logic [W-1:0] fetch_addr
);
  assign fetch_addr = align_addr(saved_addr, LOW_BITS);
endmodule

// File: rtl/rfi_out_stage.sv
module rfi_out_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= '0;
      ok <= 1'b0;
    end else begin
      ok <= load;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/rfi_restore.sv
module rfi_restore
  import rfi_pkg::*;
#(
  parameter int W          = REG_W,
  parameter int ALIGN_BITS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [W-1:0] cur_state,
  input  logic [W-1:0] saved_addr,
  input  logic [W-1:0] saved_state,
  output logic [W-1:0] new_state,
  output logic         state_ok,
  output logic [W-1:0] new_addr,
  output logic         addr_ok
);
  logic [W-1:0] merged_state;
  logic [W-1:0] fetch_addr;
  logic         ts_keep;
  logic         hv_now;
  logic         pr_return;

  rfi_state_merge #(.W(W)) u_merge (
    .cur       (cur_state),
    .saved     (saved_state),
    .merged    (merged_state),
    .ts_keep   (ts_keep),
    .hv_now    (hv_now),
    .pr_return (pr_return)
  );

  rfi_addr_align #(.W(W), .LOW_BITS(ALIGN_BITS)) u_align (
    .saved_addr (saved_addr),
    .fetch_addr (fetch_addr)
  );

  rfi_out_stage #(.W(W)) u_state_q (
    .clk (clk), .rst (rst), .load (op_valid),
    .d   (merged_state), .q (new_state), .ok (state_ok)
  );

  rfi_out_stage #(.W(W)) u_addr_q (
    .clk (clk), .rst (rst), .load (op_valid),
    .d   (fetch_addr), .q (new_addr), .ok (addr_ok)
  );
endmodule

// File: rtl/rfi_restore_chk.sv
module rfi_restore_chk (
  input logic        clk,
  input logic        rst,
  input logic        op_valid,
  input logic [63:0] cur_state,
  input logic [63:0] saved_addr,
  input logic [63:0] saved_state,
  input logic [63:0] new_state,
  input logic        state_ok,
  input logic [63:0] new_addr,
  input logic        addr_ok,
  input logic        ts_keep,
  input logic        hv_now,
  input logic        pr_return
);
  assert_hv_and_R2: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> new_state[60] == ($past(cur_state[60]) & $past(saved_state[60])));

  assert_me_gate_R3: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> new_state[12] == ($past(hv_now) ? $past(saved_state[12])
                                                 : $past(cur_state[12])));

  assert_pr_force_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && pr_return) |=> (new_state[15] && new_state[5] && new_state[4]));

  assert_ts_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ts_keep) |=> new_state[34:32] == $past(cur_state[34:32]));

  assert_ts_take_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ts_keep) |=> new_state[34:32] == $past(saved_state[34:32]));

  assert_addr_align_R7: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (new_addr[1:0] == 2'b00) && (new_addr[63:2] == $past(saved_addr[63:2])));

  assert_ok_set_R8: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> (state_ok && addr_ok));

  assert_ok_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!state_ok && !addr_ok));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(new_state) && $stable(new_addr)));

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (!state_ok && !addr_ok && new_state == '0 && new_addr == '0));
endmodule

bind rfi_restore rfi_restore_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .cur_state   (cur_state),
  .saved_addr  (saved_addr),
  .saved_state (saved_state),
  .new_state   (new_state),
  .state_ok    (state_ok),
  .new_addr    (new_addr),
  .addr_ok     (addr_ok),
  .ts_keep     (ts_keep),
  .hv_now      (hv_now),
  .pr_return   (pr_return)
);

// File: tb/rfi_restore_test.sv
`timescale 1ns/1ps
module rfi_restore_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [63:0] cur_state = '0;
  logic [63:0] saved_addr = '0;
  logic [63:0] saved_state = '0;
  logic [63:0] new_state;
  logic        state_ok;
  logic [63:0] new_addr;
  logic        addr_ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  rfi_restore uut (
    .clk (clk), .rst (rst), .op_valid (op_valid),
    .cur_state (cur_state), .saved_addr (saved_addr), .saved_state (saved_state),
    .new_state (new_state), .state_ok (state_ok),
    .new_addr (new_addr), .addr_ok (addr_ok)
  );

  // {cur_state, saved_state, saved_addr}
  localparam logic [191:0] VEC [6] = '{
    {64'h1000_0002_0000_0000, 64'hFFFF_FFF8_FFFF_FFFF, 64'h0000_1234_5678_9ABF},
    {64'h1000_0002_0000_0000, 64'h0000_0001_0000_0000, 64'h8000_0000_0000_0002},
    {64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0003},
    {64'h1000_0000_0000_0000, 64'h0000_0000_0000_4000, 64'h0123_4567_89AB_CDEF},
    {64'hA5A5_A5A5_5A5A_5A5A, 64'h5A5A_5A5A_A5A5_A5A5, 64'hDEAD_BEEF_CAFE_F00D}
  };

  // reference written per architectural bit number n (vector index 63-n)
  function automatic logic [63:0] ref_state(input logic [63:0] c, input logic [63:0] s);
    logic [63:0] r;
    logic hv, pr, keep_ts;
    hv = c[63-3];
    pr = s[63-49];
    keep_ts = ({c[63-29], c[63-30], c[63-31]} == 3'b010) &&
              ({s[63-29], s[63-30], s[63-31]} == 3'b000);
    for (int n = 0; n < 64; n++) begin
      if (n == 3)                                r[63-n] = c[63-n] & s[63-n];
      else if (n == 51)                          r[63-n] = hv ? s[63-n] : c[63-n];
      else if (n == 48 || n == 58 || n == 59)    r[63-n] = s[63-n] | pr;
      else if (n >= 29 && n <= 31)               r[63-n] = keep_ts ? c[63-n] : s[63-n];
      else if ((n >= 33 && n <= 36) || (n >= 42 && n <= 47)) r[63-n] = c[63-n];
      else                                       r[63-n] = s[63-n];
    end
    return r;
  endfunction

  function automatic logic [63:0] arch_mask(input int lo, input int hi);
    logic [63:0] m;
    m = '0;
    for (int n = lo; n <= hi; n++) m[63-n] = 1'b1;
    return m;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_state(input logic [63:0] exp);
    logic [63:0] m_copy, m_keep, m_or;
    m_copy = arch_mask(0,2) | arch_mask(4,28) | arch_mask(32,32) | arch_mask(37,41) |
             arch_mask(49,50) | arch_mask(52,57) | arch_mask(60,63);
    m_keep = arch_mask(33,36) | arch_mask(42,47);
    m_or   = arch_mask(48,48) | arch_mask(58,59);
    check("R1 copied fields", new_state & m_copy, exp & m_copy);
    check("R2 hypervisor bit", new_state & arch_mask(3,3), exp & arch_mask(3,3));
    check("R3 machine-check enable", new_state & arch_mask(51,51), exp & arch_mask(51,51));
    check("R4 forced enables", new_state & m_or, exp & m_or);
    check("R5 transaction state", new_state & arch_mask(29,31), exp & arch_mask(29,31));
    check("R6 preserved bits", new_state & m_keep, exp & m_keep);
  endtask

  // present one operation at a negedge, check outputs one negedge later
  task automatic run_op(input logic [63:0] c, input logic [63:0] s, input logic [63:0] a,
                        input bit keep_valid);
    @(negedge clk);
    cur_state = c; saved_state = s; saved_addr = a; op_valid = 1'b1;
    @(negedge clk);
    if (!keep_valid) op_valid = 1'b0;
    check_state(ref_state(c, s));
    check("R7 fetch address", new_addr, {a[63:2], 2'b00});
    check("R8 ok flags high", {62'b0, state_ok, addr_ok}, 64'd3);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held_s, held_a;
    repeat (3) @(negedge clk);
    check("R10 reset state", new_state, 64'd0);
    check("R10 reset addr", new_addr, 64'd0);
    check("R10 reset ok", {62'b0, state_ok, addr_ok}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < 6; i++)
      run_op(VEC[i][191:128], VEC[i][127:64], VEC[i][63:0], 1'b0);

    // idle: ok drops, data holds (R8, R9)
    held_s = new_state; held_a = new_addr;
    cur_state = '1; saved_state = '0; saved_addr = '1;
    repeat (3) @(negedge clk);
    check("R8 ok flags low when idle", {62'b0, state_ok, addr_ok}, 64'd0);
    check("R9 state held", new_state, held_s);
    check("R9 addr held", new_addr, held_a);

    // back-to-back operations
    run_op(VEC[0][191:128], VEC[0][127:64], VEC[0][63:0], 1'b1);
    run_op(VEC[3][191:128], VEC[3][127:64], VEC[3][63:0], 1'b0);

    // reset arriving right after an operation
    @(negedge clk);
    cur_state = VEC[5][191:128]; saved_state = VEC[5][127:64];
    saved_addr = VEC[5][63:0]; op_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; rst = 1'b0;
    check("R10 reset clears state", new_state, 64'd0);
    check("R10 reset clears addr", new_addr, 64'd0);
    check("R10 reset drops ok", {62'b0, state_ok, addr_ok}, 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule